// File: doc/BRIEF.md
# Bus Fault Retry Sequencer

This block is the glue controller for a two-processor arrangement in which memory faults can be restarted. One processor runs the normal program. A second agent repairs the address mapping. The block watches the running processor's address strobe together with a fault flag from the mapping logic. When an access faults, the running processor gets no exception. Instead, the block drives bus error, halt and bus request to it all at once. The processor then abandons the cycle and offers the bus.

When the grant arrives, the block takes the bus with a grant acknowledge and drops the error and halt lines. It holds the captured fault address for the repair agent and raises a service request. It keeps the bus until the agent pulses done and the processor has withdrawn its grant. After the bus is handed back, the processor replays the abandoned access unchanged. The block treats that replay as a new cycle and checks it for faults again.

The address strobe and bus grant from the processor are asynchronous and active low. Each passes through a two-flop synchronizer. The fault flag and the done pulse are synchronous to the block clock.

Top module: `fault_retry_seq`

## Requirements
- R1: While reset is held, and after it, bus error, halt, bus request and grant acknowledge are all high (deasserted), and fault valid and service request are low.
- R2: An asserted strobe without the fault flag, or the fault flag without a strobe, leaves all four bus outputs deasserted.
- R3: The strobe low with the fault flag high asserts bus error, halt and bus request (all driven low) together by the third rising clock edge after the inputs are applied. Grant acknowledge stays high.
- R4: Bus error, halt and bus request stay asserted, and grant acknowledge stays deasserted, for as long as the processor's bus grant stays high.
- R5: By the third rising edge after bus grant goes low, grant acknowledge is low and bus error, halt and bus request are high.
- R6: The fault address output equals the address present when the fault was detected. It stays unchanged through service, whatever later happens on the address input.
- R7: Service request and fault valid are high during service. Fault valid is low once the bus is returned. A fault flagged while an episode is in progress starts no second episode.
- R8: Grant acknowledge stays low through service until the agent's done pulse. A done pulse given before service has begun is ignored.
- R9: After done, grant acknowledge stays low while bus grant is still low. It goes high by the third rising edge after bus grant goes high.
- R10: After the bus is returned, a replayed access without a fault leaves the block quiet. A replay that faults again starts a complete new episode with a freshly captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_as_n | input | 1 | Running processor address strobe, active low, asynchronous |
| cpu_addr | input | ADDR_W | Running processor address |
| map_fault | input | 1 | Fault flag from the mapping logic, synchronous |
| cpu_bg_n | input | 1 | Bus grant from the running processor, active low, asynchronous |
| agent_done | input | 1 | One-cycle repair-complete pulse from the fault agent |
| cpu_berr_n | output | 1 | Bus error to the running processor, active low |
| cpu_halt_n | output | 1 | Halt to the running processor, active low |
| cpu_br_n | output | 1 | Bus request to the running processor, active low |
| cpu_bgack_n | output | 1 | Bus grant acknowledge, active low |
| flt_addr | output | ADDR_W | Latched fault address |
| flt_valid | output | 1 | Latched fault address is valid |
| svc_req | output | 1 | Service request to the fault agent |

## Verification
The main sequence is driven with several patterns: a strobe without a fault, a fault flag without a strobe, and fault episodes with different grant delays, service lengths and grant-hold times. The quiet patterns show that only a qualified fault starts the handshake. The varied delays show that each step waits for its own handshake input and not for a fixed count. Some episodes add a done pulse before service, or a second fault during service. These show that the sequencer ignores inputs outside their window. Replays after the bus is returned, with and without a new fault, show that every cycle is checked afresh. A scoreboard matches each service request against the address queued when that fault was injected.

// File: rtl/frs_pkg.sv
// Shared types for the bus fault retry sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package frs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RETRY_REQ  = 3'd1,
        ST_WAIT_GRANT = 3'd2,
        ST_OWN_BUS    = 3'd3,
        ST_SERVICE    = 3'd4,
        ST_RELEASE    = 3'd5
    } frs_state_e;
endpackage

// File: rtl/frs_sync.sv
// Multi-stage synchronizer for a vector of asynchronous single-bit inputs.
// Assumes: each bit is independent (no bus coherency needed); reset value
// is the inactive level of the inputs.
module frs_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/frs_addr_latch.sv
// Holds the faulting address and its valid flag for the repair agent.
// Assumes: capture and clear are never high in the same cycle.
module frs_addr_latch #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              clear,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              valid_q
);
    // Load the address on capture; it is otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (capture) addr_q <= addr_in;
    end

    // Valid flag spans from capture to accepted done.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q <= 1'b0;
        else if (capture) valid_q <= 1'b1;
        else if (clear)   valid_q <= 1'b0;
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !capture) |=> $stable(addr_q)); // R6
endmodule

// File: rtl/frs_fsm.sv
// Relinquish-and-retry state machine. Drives the running processor's
// error/halt/request lines, takes the bus on grant, holds it through
// service and returns it only after the grant is withdrawn.
// Assumes: as_s_n and bg_s_n are already synchronized; fault and done
// are synchronous to clk.
module frs_fsm
    import frs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_s_n,
    input  logic bg_s_n,
    input  logic fault,
    input  logic done,
    output logic berr_n,
    output logic halt_n,
    output logic br_n,
    output logic bgack_n,
    output logic capture,
    output logic clear,
    output logic svc_req
);
    frs_state_e state, nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (!as_s_n && fault) nxt = ST_RETRY_REQ;
            ST_RETRY_REQ:  nxt = ST_WAIT_GRANT;
            ST_WAIT_GRANT: if (!bg_s_n) nxt = ST_OWN_BUS;
            ST_OWN_BUS:    nxt = ST_SERVICE;
            ST_SERVICE:    if (done) nxt = ST_RELEASE;
            ST_RELEASE:    if (bg_s_n) nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    logic retry_act, own_act;

    // Output decode from the registered state.
    always_comb begin
        retry_act = (state == ST_RETRY_REQ) || (state == ST_WAIT_GRANT);
        own_act   = (state == ST_OWN_BUS) || (state == ST_SERVICE) ||
                    (state == ST_RELEASE);
        berr_n    = !retry_act;
        halt_n    = !retry_act;
        br_n      = !retry_act;
        bgack_n   = !own_act;
        svc_req   = (state == ST_SERVICE);
        capture   = (state == ST_IDLE) && !as_s_n && fault;
        clear     = (state == ST_SERVICE) && done;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && (as_s_n || !fault)) |=> (berr_n && bgack_n)); // R2
    AST_RETRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(berr_n) |-> $past(!as_s_n && fault)); // R3
    AST_GRANT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bgack_n) |-> $past(!bg_s_n)); // R4
    AST_SERVICE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVICE && !done) |=> (!bgack_n && state == ST_SERVICE)); // R8
    AST_BGACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bgack_n) |-> $past(bg_s_n)); // R9
endmodule

// File: rtl/fault_retry_seq.sv
// Top of the bus fault retry sequencer: synchronizes the running
// processor's strobe and grant, runs the retry state machine and holds
// the fault address for the repair agent.
// Assumes: cpu_addr is stable while the strobe is asserted.
module fault_retry_seq #(
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_as_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              map_fault,
    input  logic              cpu_bg_n,
    input  logic              agent_done,
    output logic              cpu_berr_n,
    output logic              cpu_halt_n,
    output logic              cpu_br_n,
    output logic              cpu_bgack_n,
    output logic [ADDR_W-1:0] flt_addr,
    output logic              flt_valid,
    output logic              svc_req
);
    localparam int N_ASYNC = 2;

    logic [N_ASYNC-1:0] sync_q;
    logic               capture, clear;

    frs_sync #(
        .W       (N_ASYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({N_ASYNC{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cpu_bg_n, cpu_as_n}),
        .q     (sync_q)
    );

    frs_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_s_n  (sync_q[0]),
        .bg_s_n  (sync_q[1]),
        .fault   (map_fault),
        .done    (agent_done),
        .berr_n  (cpu_berr_n),
        .halt_n  (cpu_halt_n),
        .br_n    (cpu_br_n),
        .bgack_n (cpu_bgack_n),
        .capture (capture),
        .clear   (clear),
        .svc_req (svc_req)
    );

    frs_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .clear   (clear),
        .addr_in (cpu_addr),
        .addr_q  (flt_addr),
        .valid_q (flt_valid)
    );
endmodule

// File: tb/sim_fault_retry_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: episode task queues expected fault addresses, a
// monitor pops one on every new service request and compares.
module sim_fault_retry_seq;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_as_n = 1'b1;
    logic [AW-1:0] cpu_addr = '0;
    logic          map_fault = 1'b0;
    logic          cpu_bg_n = 1'b1;
    logic          agent_done = 1'b0;
    logic          cpu_berr_n, cpu_halt_n, cpu_br_n, cpu_bgack_n;
    logic [AW-1:0] flt_addr;
    logic          flt_valid, svc_req;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [AW-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    fault_retry_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_addr(cpu_addr),
        .map_fault(map_fault), .cpu_bg_n(cpu_bg_n), .agent_done(agent_done),
        .cpu_berr_n(cpu_berr_n), .cpu_halt_n(cpu_halt_n), .cpu_br_n(cpu_br_n),
        .cpu_bgack_n(cpu_bgack_n), .flt_addr(flt_addr), .flt_valid(flt_valid),
        .svc_req(svc_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int bus4();
        return int'({cpu_berr_n, cpu_halt_n, cpu_br_n, cpu_bgack_n});
    endfunction

    // Monitor: each new service request must match the next queued address.
    bit prev_svc = 1'b0;
    always @(negedge clk) begin
        if (rst_n && svc_req && !prev_svc) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected service", int'(flt_addr), 0);
            end else begin
                logic [AW-1:0] e;
                e = exp_q.pop_front();
                chk(flt_addr == e, "R6 scoreboard", int'(flt_addr), int'(e));
            end
        end
        prev_svc = svc_req;
    end

    // One full fault episode driven from the processor and agent side.
    task automatic episode(input logic [AW-1:0] a, input int gnt_dly, input int svc_dly,
                           input int hold, input bit early_done, input bit intrude);
        exp_q.push_back(a);
        @(negedge clk);
        cpu_addr = a; cpu_as_n = 1'b0; map_fault = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!cpu_berr_n) break;
        end
        chk(bus4() == 4'b0001, "R3 retry trio", bus4(), 4'b0001);
        cpu_as_n = 1'b1; map_fault = 1'b0; cpu_addr = ~a;
        for (int i = 0; i < gnt_dly; i++) begin
            agent_done = early_done && (i == 0);
            @(negedge clk);
            chk(bus4() == 4'b0001, "R4 waiting for grant", bus4(), 4'b0001);
        end
        agent_done = 1'b0;
        cpu_bg_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!cpu_bgack_n) break;
        end
        chk(bus4() == 4'b1110, "R5 bus taken", bus4(), 4'b1110);
        @(negedge clk);
        chk(svc_req && flt_valid, "R7 service flags", int'({svc_req, flt_valid}), 3);
        if (intrude) begin
            cpu_as_n = 1'b0; map_fault = 1'b1;
            repeat (5) @(negedge clk);
            cpu_as_n = 1'b1; map_fault = 1'b0;
        end
        repeat (svc_dly) @(negedge clk);
        chk(!cpu_bgack_n && svc_req, "R8 held until done", int'({cpu_bgack_n, svc_req}), 1);
        chk(flt_addr == a, "R6 address held", int'(flt_addr), int'(a));
        agent_done = 1'b1;
        @(negedge clk);
        agent_done = 1'b0;
        chk(!svc_req && !cpu_bgack_n, "R9 release waits", int'({svc_req, cpu_bgack_n}), 0);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(!cpu_bgack_n, "R9 grant still low", int'(cpu_bgack_n), 0);
        end
        cpu_bg_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (cpu_bgack_n) break;
        end
        chk(bus4() == 4'b1111, "R9 bus returned", bus4(), 4'b1111);
        chk(!flt_valid, "R7 valid cleared", int'(flt_valid), 0);
    endtask

    // Strobe held for n cycles with a given fault flag; outputs must stay quiet.
    task automatic quiet(input logic [AW-1:0] a, input bit strobe, input bit flt, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_as_n = !strobe; map_fault = flt;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(bus4() == 4'b1111, req, bus4(), 4'b1111);
        end
        cpu_as_n = 1'b1; map_fault = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus4() == 4'b1111 && !svc_req, req, bus4(), 4'b1111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bus4() == 4'b1111 && !flt_valid && !svc_req, "R1 in reset", bus4(), 4'b1111);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus4() == 4'b1111 && !flt_valid && !svc_req, "R1 after reset", bus4(), 4'b1111);

        quiet(24'h001000, 1'b1, 1'b0, "R2 strobe no fault");
        quiet(24'h002000, 1'b0, 1'b1, "R2 fault no strobe");

        episode(24'h123456, 1, 3, 0, 1'b0, 1'b0);
        quiet(24'h123456, 1'b1, 1'b0, "R10 clean replay");
        episode(24'hABCDEF, 6, 8, 4, 1'b1, 1'b0);   // R8 early done ignored
        episode(24'h00FF00, 3, 5, 2, 1'b0, 1'b1);   // R7 intruding fault ignored
        episode(24'h00FF00, 2, 4, 1, 1'b0, 1'b0);   // R10 replay faults again
        quiet(24'h00FF00, 1'b1, 1'b0, "R10 replay after refault");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all episodes served", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule